// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block maps a 16-bit virtual address onto a 15-bit physical address through a page table. The table sits in on-chip registers and is indexed directly. The top four address bits pick one of sixteen table entries. Each entry holds a 3-bit frame number and a present flag. When the entry is present, the frame number takes the place of the page number and the 12-bit offset passes through unchanged. When the entry is absent, the block raises a fault and gives no address.

Software fills the table through a write port, one entry per cycle. A translation request is captured on a clock edge, and its result, either a valid physical address or a fault, appears one cycle later. Reset empties the table, so every request faults until entries have been written.

Top module: `pt_translator`

## Requirements
- R1: The page number is `req_vaddr[15:12]` and selects table entry 0 to 15. The offset is `req_vaddr[11:0]`.
- R2: For a translated request, `rsp_paddr[11:0]` equals the offset of the request.
- R3: For a translated request, `rsp_paddr[14:12]` equals the frame number stored in the selected entry.
- R4: With entry 2 holding frame 6 and marked present, virtual address 8196 translates to physical address 24580.
- R5: A request whose entry is absent gives `rsp_fault`=1, `rsp_valid`=0 and `rsp_paddr`=0.
- R6: The response appears on the clock edge that follows the edge capturing the request. A cycle with no request gives `rsp_valid`=0, `rsp_fault`=0 and `rsp_paddr`=0 one cycle later.
- R7: An entry write (`wr_en`=1) updates the entry at the clock edge. A request captured at that same edge sees the old contents, and any later request sees the new contents.
- R8: After reset every entry is absent, so a request to any page faults until that page's entry is written with `wr_present`=1.
- R9: `rsp_valid` and `rsp_fault` are never high together.
- R10: A write to one entry leaves the translations of all other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is present this cycle |
| req_vaddr | input | 16 | Virtual address to translate |
| wr_en | input | 1 | Write one table entry |
| wr_index | input | 4 | Entry to write |
| wr_frame | input | 3 | Frame number to store |
| wr_present | input | 1 | Present flag to store |
| rsp_valid | output | 1 | A translated address is on rsp_paddr |
| rsp_paddr | output | 15 | Physical address, or zero when not valid |
| rsp_fault | output | 1 | The previous request hit an absent entry |

## Verification
The assertions assume that the inputs change only between clock edges and that reset is held for at least one edge before the first request. They also assume that a write and a request may fall in the same cycle, since the R7 property covers that case. The bench drives every input on the falling edge and reads the outputs on the next falling edge. It holds reset for several cycles and sends same-cycle write and lookup pairs on purpose, so the stimulus stays within these limits.

// File: rtl/pt_pkg.sv
package pt_pkg;
  parameter int PT_PG_W  = 4;
  parameter int PT_OFS_W = 12;
  parameter int PT_PFN_W = 3;

  function automatic logic [PT_PFN_W+PT_OFS_W-1:0] pt_make_pa(
    input logic [PT_PFN_W-1:0] frame,
    input logic [PT_OFS_W-1:0] ofs);
    return {frame, ofs};
  endfunction

  function automatic logic [PT_PG_W-1:0] pt_page_of(
    input logic [PT_PG_W+PT_OFS_W-1:0] va);
    return va[PT_PG_W+PT_OFS_W-1:PT_OFS_W];
  endfunction

  function automatic logic [PT_OFS_W-1:0] pt_ofs_of(
    input logic [PT_PG_W+PT_OFS_W-1:0] va);
    return va[PT_OFS_W-1:0];
  endfunction
endpackage

// File: rtl/pt_entry_store.sv
module pt_entry_store #(
  parameter int PG_W  = pt_pkg::PT_PG_W,
  parameter int PFN_W = pt_pkg::PT_PFN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PG_W-1:0]  wr_index,
  input  logic [PFN_W-1:0] wr_frame,
  input  logic             wr_present,
  input  logic [PG_W-1:0]  rd_index,
  output logic [PFN_W-1:0] rd_frame,
  output logic             rd_present
);
  localparam int ENTRIES = 1 << PG_W;

  logic [PFN_W-1:0] frame_q   [ENTRIES];
  logic             present_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_index == PG_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        frame_q[g]   <= '0;
        present_q[g] <= 1'b0;
      end else if (sel) begin
        frame_q[g]   <= wr_frame;
        present_q[g] <= wr_present;
      end
    end
  end

  assign rd_frame   = frame_q[rd_index];
  assign rd_present = present_q[rd_index];
endmodule

// File: rtl/pt_lookup_stage.sv
module pt_lookup_stage #(
  parameter int OFS_W = pt_pkg::PT_OFS_W,
  parameter int PFN_W = pt_pkg::PT_PFN_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [OFS_W-1:0]       in_ofs,
  input  logic [PFN_W-1:0]       in_frame,
  input  logic                   in_present,
  output logic                   out_valid,
  output logic                   out_fault,
  output logic [PFN_W+OFS_W-1:0] out_paddr
);
  localparam int PA_W = PFN_W + OFS_W;

  logic            hit;
  logic            miss;
  logic [PA_W-1:0] pa_next;

  assign hit     = in_valid && in_present;
  assign miss    = in_valid && !in_present;
  assign pa_next = hit ? pt_pkg::pt_make_pa(in_frame, in_ofs) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_paddr <= '0;
    end else begin
      out_valid <= hit;
      out_fault <= miss;
      out_paddr <= pa_next;
    end
  end
endmodule

// File: rtl/pt_translator.sv
module pt_translator #(
  parameter int PG_W  = pt_pkg::PT_PG_W,
  parameter int OFS_W = pt_pkg::PT_OFS_W,
  parameter int PFN_W = pt_pkg::PT_PFN_W,
  localparam int VA_W = PG_W + OFS_W,
  localparam int PA_W = PFN_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             wr_en,
  input  logic [PG_W-1:0]  wr_index,
  input  logic [PFN_W-1:0] wr_frame,
  input  logic             wr_present,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault
);
  // named internal events for the checker
  logic [PG_W-1:0]  lkp_page;
  logic [OFS_W-1:0] lkp_ofs;
  logic [PFN_W-1:0] lkp_frame;
  logic             lkp_present;

  assign lkp_page = req_vaddr[VA_W-1:OFS_W];
  assign lkp_ofs  = req_vaddr[OFS_W-1:0];

  pt_entry_store #(.PG_W(PG_W), .PFN_W(PFN_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_index   (wr_index),
    .wr_frame   (wr_frame),
    .wr_present (wr_present),
    .rd_index   (lkp_page),
    .rd_frame   (lkp_frame),
    .rd_present (lkp_present)
  );

  pt_lookup_stage #(.OFS_W(OFS_W), .PFN_W(PFN_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (req_valid),
    .in_ofs     (lkp_ofs),
    .in_frame   (lkp_frame),
    .in_present (lkp_present),
    .out_valid  (rsp_valid),
    .out_fault  (rsp_fault),
    .out_paddr  (rsp_paddr)
  );
endmodule

// File: rtl/pt_translator_chk.sv
module pt_translator_chk #(
  parameter int PG_W  = 4,
  parameter int OFS_W = 12,
  parameter int PFN_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [PG_W+OFS_W-1:0]  req_vaddr,
  input logic                   wr_en,
  input logic [PG_W-1:0]        wr_index,
  input logic                   wr_present,
  input logic                   rsp_valid,
  input logic [PFN_W+OFS_W-1:0] rsp_paddr,
  input logic                   rsp_fault,
  input logic [PFN_W-1:0]       lkp_frame,
  input logic                   lkp_present
);
  logic            last_wr_en;
  logic [PG_W-1:0] last_wr_idx;
  logic            last_wr_present;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_wr_en      <= 1'b0;
      last_wr_idx     <= '0;
      last_wr_present <= 1'b0;
    end else begin
      last_wr_en      <= wr_en;
      last_wr_idx     <= wr_index;
      last_wr_present <= wr_present;
    end
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_fault));

  p_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_valid || rsp_fault));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault && rsp_paddr == '0));

  p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lkp_present) |=> rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]));

  p_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lkp_present) |=> (rsp_valid && rsp_paddr[PFN_W+OFS_W-1:OFS_W] == $past(lkp_frame)));

  p_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lkp_present) |=> (rsp_fault && !rsp_valid && rsp_paddr == '0));

  p_newwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && last_wr_en && req_vaddr[PG_W+OFS_W-1:OFS_W] == last_wr_idx)
      |=> (rsp_fault == !$past(last_wr_present)));
endmodule

bind pt_translator pt_translator_chk #(.PG_W(PG_W), .OFS_W(OFS_W), .PFN_W(PFN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_vaddr   (req_vaddr),
  .wr_en       (wr_en),
  .wr_index    (wr_index),
  .wr_present  (wr_present),
  .rsp_valid   (rsp_valid),
  .rsp_paddr   (rsp_paddr),
  .rsp_fault   (rsp_fault),
  .lkp_frame   (lkp_frame),
  .lkp_present (lkp_present)
);

// File: tb/pt_translator_bench.sv
module pt_translator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_index = '0;
  logic [2:0]  wr_frame = '0;
  logic        wr_present = 1'b0;
  logic        rsp_valid;
  logic [14:0] rsp_paddr;
  logic        rsp_fault;

  int total = 0;
  int bad = 0;

  // bench-side table image
  logic [2:0] m_frame [16];
  logic       m_pres  [16];

  always #5 clk = ~clk;

  pt_translator u_pt_translator (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .wr_en(wr_en), .wr_index(wr_index), .wr_frame(wr_frame), .wr_present(wr_present),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  task automatic check(input string req, input logic v, input logic f, input logic [14:0] pa,
                       input logic ev, input logic ef, input logic [14:0] epa);
    total++;
    if (v !== ev || f !== ef || pa !== epa) begin
      bad++;
      $display("FAIL %s: got valid=%0b fault=%0b pa=%0d, want valid=%0b fault=%0b pa=%0d",
               req, v, f, pa, ev, ef, epa);
    end
  endtask

  // expected response to a virtual address, from the table image
  task automatic expect_for(input logic [15:0] va, output logic ev, output logic ef,
                            output logic [14:0] epa);
    int pg;
    pg = int'(va / 16'd4096);
    ev = m_pres[pg];
    ef = !m_pres[pg];
    epa = m_pres[pg] ? 15'(int'(m_frame[pg]) * 4096 + int'(va % 16'd4096)) : 15'd0;
  endtask

  task automatic put_entry(input int idx, input int frm, input logic pres);
    wr_en = 1'b1; wr_index = 4'(idx); wr_frame = 3'(frm); wr_present = pres;
    @(negedge clk);
    wr_en = 1'b0;
    m_frame[idx] = 3'(frm); m_pres[idx] = pres;
  endtask

  task automatic lookup(input string req, input logic [15:0] va);
    logic ev, ef; logic [14:0] epa;
    expect_for(va, ev, ef, epa);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, rsp_valid, rsp_fault, rsp_paddr, ev, ef, epa);
  endtask

  task automatic t_reset;
    check("R6 reset outputs", rsp_valid, rsp_fault, rsp_paddr, 1'b0, 1'b0, 15'd0);
    for (int p = 0; p < 16; p++) lookup("R8 empty table faults", 16'(p * 4096 + 17 * p));
  endtask

  task automatic t_example;
    put_entry(2, 6, 1'b1);
    lookup("R4 example 8196", 16'd8196);
    check("R4 fixed value", rsp_valid, rsp_fault, rsp_paddr, 1'b1, 1'b0, 15'd24580);
  endtask

  task automatic t_full_table;
    for (int i = 0; i < 16; i++) put_entry(i, (i * 5 + 3) % 8, (i != 7) && (i != 13));
    for (int i = 0; i < 16; i++) lookup("R1 R3 page select", 16'(i * 4096 + i * 251));
    lookup("R2 offset max", 16'h0FFF);
    lookup("R2 offset zero", 16'hF000);
    lookup("R5 absent page 7", 16'h7ABC);
    lookup("R5 absent page 13", 16'hD001);
  endtask

  task automatic t_isolation;
    put_entry(9, 0, 1'b0);
    lookup("R10 written entry", 16'h9123);
    lookup("R10 neighbour 8", 16'h8123);
    lookup("R10 neighbour 10", 16'hA456);
  endtask

  task automatic t_same_cycle;
    logic ev, ef; logic [14:0] epa;
    // entry 4 currently present; write absent while looking it up
    expect_for(16'h4321, ev, ef, epa);
    req_valid = 1'b1; req_vaddr = 16'h4321;
    wr_en = 1'b1; wr_index = 4'd4; wr_frame = 3'd1; wr_present = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    check("R7 same-cycle sees old", rsp_valid, rsp_fault, rsp_paddr, ev, ef, epa);
    m_frame[4] = 3'd1; m_pres[4] = 1'b0;
    lookup("R7 next sees new", 16'h4321);
    put_entry(4, 5, 1'b1);
    lookup("R7 reload visible", 16'h4FFE);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R6 idle cycle", rsp_valid, rsp_fault, rsp_paddr, 1'b0, 1'b0, 15'd0);
    lookup("R9 back-to-back a", 16'h1001);
    lookup("R9 back-to-back b", 16'h7001);
    @(negedge clk);
    check("R6 idle after fault", rsp_valid, rsp_fault, rsp_paddr, 1'b0, 1'b0, 15'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_frame[i] = '0; m_pres[i] = 1'b0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_example;
    t_full_table;
    t_isolation;
    t_same_cycle;
    t_idle;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got running, want finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule